// File: doc/BRIEF.md
# Reset Qualifier and Reset Pulse Stretcher

This block turns a noisy, bidirectional reset pin into a clean internal reset for a small microcontroller core. The pin level is synchronised into the oscillator clock domain. A counter then measures how long the pin has stayed asserted without a break. The core reset is declared only once that run reaches the qualification length. A single sampled release clears the progress. The reset stays asserted while the pin stays asserted, plus a short tail after release.

Any internal source, such as a watchdog, can raise a request line. The block then pulls the reset pin to its asserted level for a guaranteed minimum number of oscillator periods, so that outside devices see the reset too. While it drives the pin, it does not count the pin level, so it cannot retrigger on its own echo. When a reset is recognised while the core reports idle or power-down, a one-cycle wake pulse brings the core back to normal operation.

Top module: `rst_qual_top`

## Requirements
- R1: With default parameters, once the pin is seen asserted on 64 consecutive rising edges, core_rst goes high at the 67th edge, counting the first edge that sampled the pin asserted as the 1st.
- R2: A run of 63 or fewer consecutive asserted samples never raises core_rst. A single sampled release restarts the count, so two runs of 40 separated by one released cycle also leave core_rst low.
- R3: After qualification, core_rst stays high while the pin stays asserted. It goes low at the 4th edge, counting the first edge that samples the pin released as the 1st.
- R4: When any int_req bit is high at a rising edge, pin_oe goes high at that edge. It stays high up to and including the 11th edge after the last edge that sampled a request, so one request gives exactly 12 cycles of drive.
- R5: core_rst is high in every cycle in which pin_oe is high, and it rises at the same edge as pin_oe.
- R6: While pin_oe is high, the pin level is not counted. If the pin stays asserted from outside, core_rst goes low when the drive ends. It rises again 66 edges after the last edge at which pin_oe was high.
- R7: wake_pls is high for exactly one cycle, at the edge where core_rst rises, if idle_st or pdown_st was high at that edge. In all other cycles it is low.
- R8: With PIN_ACTIVE_LOW = 1 (the default), a low pin_lvl means asserted and a high pin_lvl means released.
- R9: While arst_n is low, core_rst is 1, pin_oe is 0 and wake_pls is 0. At the first edge after arst_n rises, with the pin released and no request present, core_rst goes low.
- R10: Each int_req bit on its own, and any combination of bits, starts the drive described in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| arst_n | input | 1 | Power-on reset of this block, active low, asynchronous assert |
| pin_lvl | input | 1 | Sampled level of the reset pin, polarity set by PIN_ACTIVE_LOW |
| int_req | input | NUM_REQ | Internal reset requests, one bit per source |
| idle_st | input | 1 | Core is in idle state |
| pdown_st | input | 1 | Core is in power-down state |
| core_rst | output | 1 | Internal reset to the core and port logic, active high |
| pin_oe | output | 1 | Drive enable pulling the pin to its asserted level |
| wake_pls | output | 1 | One-cycle wake request to the core |

## Verification
Single external pulses of 63, 64 and 100 samples separate the qualification boundary from the release tail. A pulse split by one released sample shows that progress is cleared rather than kept. Internal requests of one cycle, several cycles, and on different request bits measure the stretch length and show that the sources are combined with OR. A watchdog-style request made while the pin is also held asserted from outside shows that the pin echo is ignored and that qualification restarts from zero. Random pulse lengths across the 64 boundary, with random idle and power-down flags, check the timing of the wake pulse against the rising edge of the reset.

// File: rtl/rst_qual_pkg.sv
package rst_qual_pkg;

   // Bits needed to hold the values 0..limit
   function automatic int cnt_bits(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/rst_qual_sync.sv
module rst_qual_sync #(
   parameter int STAGES     = 2,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic clk_osc,
   input  logic arst_n,
   input  logic pin_lvl,
   output logic pin_act
);

   logic              pin_norm;
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rst_qual_sync: STAGES must be at least 2");
      end
      if (ACTIVE_LOW) begin : g_pol_low
         assign pin_norm = ~pin_lvl;
      end else begin : g_pol_high
         assign pin_norm = pin_lvl;
      end
   endgenerate

   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], pin_norm};
   end

   assign pin_act = chain_q[STAGES-1];

endmodule

// File: rtl/rst_qual_count.sv
module rst_qual_count #(
   parameter int QUAL_CYCLES = 64
) (
   input  logic clk_osc,
   input  logic arst_n,
   input  logic pin_act,
   input  logic blank,
   output logic qual_hit
);

   localparam int CW = rst_qual_pkg::cnt_bits(QUAL_CYCLES);
   localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

   logic [CW-1:0] run_q;

   generate
      if (QUAL_CYCLES < 2) begin : g_bad_qual
         $error("rst_qual_count: QUAL_CYCLES must be at least 2");
      end
   endgenerate

   // Saturating run counter, cleared by a release or by own drive
   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n)                 run_q <= '0;
      else if (blank || !pin_act)  run_q <= '0;
      else if (run_q != LIMIT)     run_q <= run_q + CW'(1);
   end

   assign qual_hit = (run_q == LIMIT);

endmodule

// File: rtl/rst_qual_stretch.sv
module rst_qual_stretch #(
   parameter int STRETCH_CYCLES = 12,
   parameter int NUM_REQ        = 2
) (
   input  logic               clk_osc,
   input  logic               arst_n,
   input  logic [NUM_REQ-1:0] int_req,
   output logic               drv_nxt,
   output logic               drv_q
);

   localparam int SW = rst_qual_pkg::cnt_bits(STRETCH_CYCLES);
   localparam logic [SW-1:0] LOAD = SW'(STRETCH_CYCLES);

   logic [SW-1:0] left_q;
   logic [SW-1:0] left_nxt;
   logic          req_any;

   generate
      if (STRETCH_CYCLES < 1) begin : g_bad_stretch
         $error("rst_qual_stretch: STRETCH_CYCLES must be at least 1");
      end
      if (NUM_REQ < 1) begin : g_bad_req
         $error("rst_qual_stretch: NUM_REQ must be at least 1");
      end
   endgenerate

   assign req_any = |int_req;

   always_comb begin
      if (req_any)              left_nxt = LOAD;
      else if (left_q != '0)    left_nxt = left_q - SW'(1);
      else                      left_nxt = '0;
   end

   assign drv_nxt = (left_nxt != '0);

   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n) begin
         left_q <= '0;
         drv_q  <= 1'b0;
      end else begin
         left_q <= left_nxt;
         drv_q  <= drv_nxt;
      end
   end

endmodule

// File: rtl/rst_qual_out.sv
module rst_qual_out (
   input  logic clk_osc,
   input  logic arst_n,
   input  logic qual_hit,
   input  logic drv_nxt,
   input  logic idle_st,
   input  logic pdown_st,
   output logic core_rst,
   output logic wake_pls
);

   logic rst_d;
   logic rst_q;
   logic wake_q;

   assign rst_d = qual_hit | drv_nxt;

   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n) begin
         rst_q  <= 1'b1;
         wake_q <= 1'b0;
      end else begin
         rst_q  <= rst_d;
         wake_q <= rst_d & ~rst_q & (idle_st | pdown_st);
      end
   end

   assign core_rst = rst_q;
   assign wake_pls = wake_q;

endmodule

// File: rtl/rst_qual_top.sv
module rst_qual_top #(
   parameter int QUAL_CYCLES    = 64,
   parameter int STRETCH_CYCLES = 12,
   parameter int SYNC_STAGES    = 2,
   parameter int NUM_REQ        = 2,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input  logic               clk_osc,
   input  logic               arst_n,
   input  logic               pin_lvl,
   input  logic [NUM_REQ-1:0] int_req,
   input  logic               idle_st,
   input  logic               pdown_st,
   output logic               core_rst,
   output logic               pin_oe,
   output logic               wake_pls
);

   logic pin_act;
   logic qual_hit;
   logic drv_nxt;
   logic drv_q;

   rst_qual_sync #(
      .STAGES     (SYNC_STAGES),
      .ACTIVE_LOW (PIN_ACTIVE_LOW)
   ) sync_i (
      .clk_osc (clk_osc),
      .arst_n  (arst_n),
      .pin_lvl (pin_lvl),
      .pin_act (pin_act)
   );

   rst_qual_count #(
      .QUAL_CYCLES (QUAL_CYCLES)
   ) count_i (
      .clk_osc  (clk_osc),
      .arst_n   (arst_n),
      .pin_act  (pin_act),
      .blank    (drv_q),
      .qual_hit (qual_hit)
   );

   rst_qual_stretch #(
      .STRETCH_CYCLES (STRETCH_CYCLES),
      .NUM_REQ        (NUM_REQ)
   ) stretch_i (
      .clk_osc (clk_osc),
      .arst_n  (arst_n),
      .int_req (int_req),
      .drv_nxt (drv_nxt),
      .drv_q   (drv_q)
   );

   rst_qual_out out_i (
      .clk_osc  (clk_osc),
      .arst_n   (arst_n),
      .qual_hit (qual_hit),
      .drv_nxt  (drv_nxt),
      .idle_st  (idle_st),
      .pdown_st (pdown_st),
      .core_rst (core_rst),
      .wake_pls (wake_pls)
   );

   assign pin_oe = drv_q;

endmodule

// File: rtl/rst_qual_chk.sv
module rst_qual_chk #(
   parameter int QUAL_CYCLES    = 64,
   parameter int STRETCH_CYCLES = 12,
   parameter int SYNC_STAGES    = 2,
   parameter int NUM_REQ        = 2,
   parameter bit PIN_ACTIVE_LOW = 1'b1
) (
   input logic               clk_osc,
   input logic               arst_n,
   input logic               pin_lvl,
   input logic [NUM_REQ-1:0] int_req,
   input logic               idle_st,
   input logic               pdown_st,
   input logic               core_rst,
   input logic               pin_oe,
   input logic               wake_pls
);

   localparam int PW = rst_qual_pkg::cnt_bits(QUAL_CYCLES);
   localparam int OW = rst_qual_pkg::cnt_bits(STRETCH_CYCLES);

   logic [PW-1:0]        pin_run;
   logic [OW-1:0]        oe_run;
   logic [SYNC_STAGES:0] full_dly;
   logic                 pin_on;
   logic                 full;

   assign pin_on = PIN_ACTIVE_LOW ? ~pin_lvl : pin_lvl;
   assign full   = (pin_run == PW'(QUAL_CYCLES));

   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n) begin
         pin_run  <= '0;
         oe_run   <= '0;
         full_dly <= '0;
      end else begin
         if (!pin_on)  pin_run <= '0;
         else if (!full) pin_run <= pin_run + PW'(1);
         if (!pin_oe) oe_run <= '0;
         else if (oe_run != OW'(STRETCH_CYCLES)) oe_run <= oe_run + OW'(1);
         full_dly <= {full_dly[SYNC_STAGES-1:0], full};
      end
   end

   AST_QUAL_NEEDS_RUN: assert property (@(posedge clk_osc) disable iff (!arst_n)
      ($rose(core_rst) && !pin_oe) |-> (|full_dly)); // R1

   AST_REQ_STARTS_DRIVE: assert property (@(posedge clk_osc) disable iff (!arst_n)
      (|int_req) |=> pin_oe); // R4

   AST_DRIVE_MIN_LEN: assert property (@(posedge clk_osc) disable iff (!arst_n)
      $fell(pin_oe) |-> (oe_run == OW'(STRETCH_CYCLES))); // R4

   AST_DRIVE_HOLDS_RST: assert property (@(posedge clk_osc) disable iff (!arst_n)
      pin_oe |-> core_rst); // R5

   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_osc) disable iff (!arst_n)
      wake_pls |=> !wake_pls); // R7

   AST_WAKE_ON_RISE: assert property (@(posedge clk_osc) disable iff (!arst_n)
      wake_pls |-> ($rose(core_rst) && $past(idle_st | pdown_st))); // R7

   AST_WAKE_WHEN_ASLEEP: assert property (@(posedge clk_osc) disable iff (!arst_n)
      ($rose(core_rst) && $past(idle_st | pdown_st)) |-> wake_pls); // R7

endmodule

bind rst_qual_top rst_qual_chk #(
   .QUAL_CYCLES    (QUAL_CYCLES),
   .STRETCH_CYCLES (STRETCH_CYCLES),
   .SYNC_STAGES    (SYNC_STAGES),
   .NUM_REQ        (NUM_REQ),
   .PIN_ACTIVE_LOW (PIN_ACTIVE_LOW)
) chk_i (
   .clk_osc  (clk_osc),
   .arst_n   (arst_n),
   .pin_lvl  (pin_lvl),
   .int_req  (int_req),
   .idle_st  (idle_st),
   .pdown_st (pdown_st),
   .core_rst (core_rst),
   .pin_oe   (pin_oe),
   .wake_pls (wake_pls)
);

// File: tb/rst_qual_top_tb.sv
module rst_qual_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int QUAL       = 64;
   localparam int STR        = 12;
   localparam int SYNC       = 2;
   localparam int NREQ       = 2;
   localparam bit ACT_LOW    = 1'b1;

   logic            clk = 1'b0;
   logic            arst_n;
   logic            ext_hold;
   logic [NREQ-1:0] int_req;
   logic            idle_st;
   logic            pdown_st;
   logic            pin_lvl;
   logic            core_rst;
   logic            pin_oe;
   logic            wake_pls;

   int nvec  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Wired pin: asserted when either the outside world or the block pulls it
   assign pin_lvl = ACT_LOW ? ~(ext_hold | pin_oe) : (ext_hold | pin_oe);

   rst_qual_top #(
      .QUAL_CYCLES    (QUAL),
      .STRETCH_CYCLES (STR),
      .SYNC_STAGES    (SYNC),
      .NUM_REQ        (NREQ),
      .PIN_ACTIVE_LOW (ACT_LOW)
   ) dut_i (
      .clk_osc  (clk),
      .arst_n   (arst_n),
      .pin_lvl  (pin_lvl),
      .int_req  (int_req),
      .idle_st  (idle_st),
      .pdown_st (pdown_st),
      .core_rst (core_rst),
      .pin_oe   (pin_oe),
      .wake_pls (wake_pls)
   );

   // k = number of rising edges since the pulse started (first edge is 1)
   function automatic bit exp_ext_rst(input int len, input int k);
      return (len >= QUAL) && (k >= QUAL + SYNC + 1) && (k <= len + SYNC + 1);
   endfunction

   function automatic bit exp_ext_wake(input int len, input int k, input bit slp);
      return (len >= QUAL) && (k == QUAL + SYNC + 1) && slp;
   endfunction

   function automatic bit exp_drv(input int r, input int k);
      return (k >= 1) && (k <= r + STR - 1);
   endfunction

   task automatic chk(input logic act, input bit exp, input string req, input string what);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic ext_pulse(input int len, input bit idl, input bit pdn, input string req);
      int last;
      last = ((len > QUAL + SYNC + 1) ? len : QUAL + SYNC + 1) + SYNC + 4;
      idle_st  = idl;
      pdown_st = pdn;
      ext_hold = 1'b1;
      for (int k = 1; k <= last; k++) begin
         @(negedge clk);
         chk(core_rst, exp_ext_rst(len, k), req, $sformatf("core_rst len=%0d k=%0d", len, k));
         chk(wake_pls, exp_ext_wake(len, k, idl | pdn), "R7", $sformatf("wake len=%0d k=%0d", len, k));
         if (k == len) ext_hold = 1'b0;
      end
      idle_st  = 1'b0;
      pdown_st = 1'b0;
   endtask

   task automatic int_pulse(input int r, input logic [NREQ-1:0] mask, input bit idl, input bit pdn,
                            input string req);
      idle_st  = idl;
      pdown_st = pdn;
      int_req  = mask;
      for (int k = 1; k <= r + STR + 4; k++) begin
         @(negedge clk);
         chk(pin_oe, exp_drv(r, k), req, $sformatf("pin_oe r=%0d k=%0d", r, k));
         chk(core_rst, exp_drv(r, k), "R5", $sformatf("core_rst r=%0d k=%0d", r, k));
         chk(wake_pls, (k == 1) && (idl | pdn), "R7", $sformatf("wake r=%0d k=%0d", r, k));
         if (k == r) int_req = '0;
      end
      idle_st  = 1'b0;
      pdown_st = 1'b0;
   endtask

   // One-cycle request while the pin is also held asserted from outside
   task automatic drive_over_pin(input int hold);
      int d;
      d = STR;
      idle_st  = 1'b1;
      int_req  = 1;
      ext_hold = 1'b1;
      for (int k = 1; k <= hold + SYNC + 5; k++) begin
         @(negedge clk);
         chk(pin_oe, k <= d, "R4", $sformatf("pin_oe over pin k=%0d", k));
         chk(core_rst, (k <= d) || ((k >= d + QUAL + 2) && (k <= hold + SYNC + 1)), "R6",
             $sformatf("core_rst over pin k=%0d", k));
         chk(wake_pls, (k == 1) || (k == d + QUAL + 2), "R7", $sformatf("wake over pin k=%0d", k));
         if (k == 1) int_req = '0;
         if (k == hold) ext_hold = 1'b0;
      end
      idle_st = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd5151));
      arst_n   = 1'b0;
      ext_hold = 1'b0;
      int_req  = '0;
      idle_st  = 1'b0;
      pdown_st = 1'b0;
      repeat (3) @(negedge clk);
      chk(core_rst, 1'b1, "R9", "core_rst in reset");
      chk(pin_oe,   1'b0, "R9", "pin_oe in reset");
      chk(wake_pls, 1'b0, "R9", "wake in reset");
      arst_n = 1'b1;
      @(negedge clk);
      chk(core_rst, 1'b0, "R9", "core_rst after release");
      repeat (4) @(negedge clk);

      ext_pulse(63, 1'b0, 1'b0, "R2");
      ext_pulse(64, 1'b0, 1'b0, "R1");
      ext_pulse(100, 1'b0, 1'b0, "R3");
      ext_pulse(70, 1'b1, 1'b0, "R8");
      ext_pulse(66, 1'b0, 1'b1, "R7");
      ext_pulse(20, 1'b1, 1'b1, "R2");

      // Two runs of 40 split by one released sample: never qualifies (R2)
      ext_hold = 1'b1;
      for (int k = 1; k <= 90; k++) begin
         @(negedge clk);
         chk(core_rst, 1'b0, "R2", $sformatf("split run k=%0d", k));
         if (k == 40) ext_hold = 1'b0;
         if (k == 41) ext_hold = 1'b1;
         if (k == 81) ext_hold = 1'b0;
      end
      repeat (4) @(negedge clk);

      int_pulse(1, 2'b01, 1'b0, 1'b0, "R4");
      int_pulse(5, 2'b10, 1'b1, 1'b0, "R10");
      int_pulse(3, 2'b11, 1'b0, 1'b1, "R4");
      int_pulse(2, 2'b01, 1'b0, 1'b0, "R10");
      drive_over_pin(120);
      repeat (4) @(negedge clk);

      for (int i = 0; i < 16; i++) begin
         int len;
         len = 56 + int'($urandom % 16);
         ext_pulse(len, bit'($urandom & 1), bit'($urandom & 1), "R1");
      end
      for (int i = 0; i < 10; i++) begin
         int r;
         logic [NREQ-1:0] m;
         r = 1 + int'($urandom % 8);
         m = NREQ'(1 + ($urandom % 3));
         int_pulse(r, m, bit'($urandom & 1), 1'b0, "R4");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

endmodule